// File: doc/BRIEF.md
# Global Standby Inactivity Timer

This block watches for system-wide inactivity. Once enabled with a non-zero interval, it counts down one step per slow tick, each tick standing for 8 s. If the count runs out, the block raises a single-cycle management interrupt and sets a sticky cause bit. The programmable range is 1 to 255 ticks, which is 8 s up to roughly 34 minutes. The timer then starts the next interval on its own, so it can fire again.

Several unrelated conditions restart the countdown from the programmed interval:
- switching the enable on;
- the timer's own expiry;
- a pulse saying that any local device standby timer was reloaded;
- any of three system-event pulses whose mask bit is set.

A restart in the same cycle as a tick takes priority over the tick. An interval of zero is not a legal setting. With it, the counter holds and never fires.

Software reaches the block through a small write/read register port with four words. Word 0 holds the interval. Word 1 holds the controls: bit 0 is the enable, and bits 3:1 are the event masks, where bit 1+i admits event i. Word 2 holds the sticky status in bit 0, which is cleared by writing 1. Word 3 returns the live count and is read-only. Reads are combinational on the same address lines.

Top module: `gsit_top`

## Requirements
- R1: After a synchronous reset, interval, enable, masks, status, count and irq_o are all zero.
- R2: While enabled with a legal interval N, each tick lowers the count by one. irq_o pulses in the cycle after the tick that finds the count at 1.
- R3: While the enable is 0, ticks and reload inputs leave the count unchanged and irq_o stays low.
- R4: Writing word 1 with bit 0 set while the enable is 0 loads the count with the interval. Writing bit 0 set while already enabled does not reload.
- R5: Expiry loads the count with the interval, so the timer fires again after another N ticks, or on every tick when N is 1.
- R6: A pulse on local_reload_i while enabled loads the count with the interval.
- R7: sys_evt_i[i] reloads the count only while word 1 bit 1+i is set. An unmasked event has no effect.
- R8: If a reload and a tick arrive in the same cycle, the count takes the interval and irq_o stays low, even when the count was 1.
- R9: With an interval of 0, ticks leave the count unchanged and irq_o never rises. A reload then loads 0.
- R10: The status bit (status_o, word 2 bit 0) sets on each expiry. Writing 1 clears it and writing 0 has no effect. An expiry in the same cycle as a clearing write leaves it set.
- R11: Each expiry produces exactly one cycle of irq_o. A cycle without an expiring tick gives irq_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register word select, for both writes and reads |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Read data of the selected word |
| sys_evt_i | input | 3 | System activity event pulses |
| local_reload_i | input | 1 | Pulse: some local standby timer was reloaded |
| tick_en_i | input | 1 | One-cycle pulse per 8 s time base step |
| irq_o | output | 1 | Management interrupt pulse |
| status_o | output | 1 | Sticky expiry cause bit |

## Verification
Two collisions can land in the same cycle. The first is a restart (a local reload pulse or an admitted event) together with a tick that would otherwise expire the count at 1. The bench brings the count to 1 and then drives both inputs in one cycle. It judges the result by irq_o staying low and the count word reading the full interval. The second collision is an expiring tick together with a write of 1 to the status word. It is judged by irq_o rising while status_o stays set.

// File: rtl/gsit_pkg.sv
package gsit_pkg;

    localparam int CNT_W  = 8;
    localparam int EVT_N  = 3;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MASK_LSB = 1;
    localparam int STAT_BIT      = 0;

    typedef enum logic [ADDR_W-1:0] {
        W_IVAL = 2'd0,
        W_CTRL = 2'd1,
        W_STAT = 2'd2,
        W_CNT  = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] ival;
        logic [EVT_N-1:0] evt_mask;
        logic             enable;
    } cfg_t;

    typedef struct packed {
        logic en_rise;
        logic local_hit;
        logic evt_hit;
    } reload_src_t;

    function automatic logic ival_legal(input logic [CNT_W-1:0] v);
        return v != '0;
    endfunction

    function automatic logic any_src(input reload_src_t s);
        return s.en_rise | s.local_hit | s.evt_hit;
    endfunction

endpackage

// File: rtl/gsit_regs.sv
module gsit_regs
    import gsit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              status_set,
    input  logic [CNT_W-1:0]  cnt,
    output cfg_t              cfg,
    output logic              en_rise,
    output logic              status,
    output logic [DATA_W-1:0] rdata
);

    word_sel_e sel;
    logic      wr_ival;
    logic      wr_ctrl;
    logic      wr_clr;

    always_comb begin
        sel     = word_sel_e'(addr);
        wr_ival = we && (sel == W_IVAL);
        wr_ctrl = we && (sel == W_CTRL);
        wr_clr  = we && (sel == W_STAT) && wdata[STAT_BIT];
        en_rise = wr_ctrl && wdata[CTRL_EN_BIT] && !cfg.enable;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            status <= 1'b0;
        end else begin
            if (wr_ival) begin
                cfg.ival <= wdata[CNT_W-1:0];
            end
            if (wr_ctrl) begin
                cfg.enable   <= wdata[CTRL_EN_BIT];
                cfg.evt_mask <= wdata[CTRL_MASK_LSB +: EVT_N];
            end
            // an expiry outranks a clearing write in the same cycle
            if (status_set) begin
                status <= 1'b1;
            end else if (wr_clr) begin
                status <= 1'b0;
            end
        end
    end

    always_comb begin
        case (sel)
            W_IVAL:  rdata = DATA_W'(cfg.ival);
            W_CTRL:  rdata = DATA_W'({cfg.evt_mask, cfg.enable});
            W_STAT:  rdata = DATA_W'(status);
            default: rdata = DATA_W'(cnt);
        endcase
    end

endmodule

// File: rtl/gsit_reload.sv
module gsit_reload
    import gsit_pkg::*;
(
    input  cfg_t             cfg,
    input  logic             en_rise,
    input  logic [EVT_N-1:0] evt,
    input  logic             local_reload,
    output reload_src_t      src,
    output logic             reload
);

    logic [EVT_N-1:0] hit;

    for (genvar i = 0; i < EVT_N; i++) begin : g_evt
        assign hit[i] = evt[i] & cfg.evt_mask[i];
    end

    always_comb begin
        src.en_rise   = en_rise;
        src.local_hit = cfg.enable & local_reload;
        src.evt_hit   = cfg.enable & (|hit);
        reload        = any_src(src);
    end

endmodule

// File: rtl/gsit_counter.sv
module gsit_counter
    import gsit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic             reload,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    always_comb begin
        // a reload in the same cycle swallows the tick
        step   = cfg.enable && tick && !reload && ival_legal(cfg.ival);
        expire = step && (cnt == ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= expire;
            if (reload || expire) begin
                cnt <= cfg.ival;
            end else if (step && (cnt > ONE)) begin
                cnt <= cnt - ONE;
            end
        end
    end

endmodule

// File: rtl/gsit_top.sv
module gsit_top
    import gsit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    input  logic [EVT_N-1:0]  sys_evt_i,
    input  logic              local_reload_i,
    input  logic              tick_en_i,
    output logic              irq_o,
    output logic              status_o
);

    cfg_t             cfg;
    logic             en_rise;
    reload_src_t      src;
    logic             reload;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;

    gsit_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we_i),
        .addr       (cfg_addr_i),
        .wdata      (cfg_wdata_i),
        .status_set (expire),
        .cnt        (cnt_q),
        .cfg        (cfg),
        .en_rise    (en_rise),
        .status     (status_o),
        .rdata      (cfg_rdata_o)
    );

    gsit_reload u_reload (
        .cfg          (cfg),
        .en_rise      (en_rise),
        .evt          (sys_evt_i),
        .local_reload (local_reload_i),
        .src          (src),
        .reload       (reload)
    );

    gsit_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .reload (reload),
        .tick   (tick_en_i),
        .cnt    (cnt_q),
        .expire (expire),
        .irq    (irq_o)
    );

endmodule

// File: rtl/gsit_chk.sv
module gsit_chk
    import gsit_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq,
    input logic              status,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  ival,
    input logic              en,
    input logic [EVT_N-1:0]  mask,
    input logic [EVT_N-1:0]  evt,
    input logic              lrl,
    input logic              tick,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata
);

    logic restart;
    logic ctrl_on_from_off;
    assign restart          = en && (lrl || (|(evt & mask)));
    assign ctrl_on_from_off = we && (addr == W_CTRL) && wdata[CTRL_EN_BIT] && !en;

    assert_irq_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(tick) && $past(en)));

    assert_decrement_R2: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !we && !restart && ival != '0 && cnt > CNT_W'(1))
        |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
        (!en && !we) |=> ($stable(cnt) && !irq));

    assert_enable_loads_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_on_from_off |=> (cnt == $past(ival)));

    assert_restart_wins_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!irq && cnt == $past(ival)));

    assert_illegal_silent_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(ival) != '0));

    assert_status_follows_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> status);

endmodule

bind gsit_top gsit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .irq    (irq_o),
    .status (status_o),
    .cnt    (cnt_q),
    .ival   (cfg.ival),
    .en     (cfg.enable),
    .mask   (cfg.evt_mask),
    .evt    (sys_evt_i),
    .lrl    (local_reload_i),
    .tick   (tick_en_i),
    .we     (cfg_we_i),
    .addr   (cfg_addr_i),
    .wdata  (cfg_wdata_i)
);

// File: tb/sim_gsit_top.sv
`timescale 1ns/1ps
module sim_gsit_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] evt = 3'd0;
    logic       lrl = 1'b0;
    logic       tick = 1'b0;
    logic       irq;
    logic       status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gsit_top u0 (
        .clk(clk), .rst(rst), .cfg_we_i(we), .cfg_addr_i(addr),
        .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .sys_evt_i(evt),
        .local_reload_i(lrl), .tick_en_i(tick), .irq_o(irq), .status_o(status)
    );

    // {we, addr, wdata, evt, lrl, tick, expected count, expected irq}
    localparam logic [24:0] TBL [0:NVEC-1] = '{
        {1'b1, 2'd0, 8'h03, 3'b000, 1'b0, 1'b0, 8'd0, 1'b0}, // interval 3, still off
        {1'b1, 2'd1, 8'h01, 3'b000, 1'b0, 1'b0, 8'd3, 1'b0}, // R4 enable loads
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd2, 1'b0}, // R2
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd1, 1'b0}, // R2
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd3, 1'b1}, // R2 R5 fire and reload
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd2, 1'b0}, // R11 single pulse
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 1'b0, 8'd3, 1'b0}, // R6 local reload
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd2, 1'b0}, // R2
        {1'b0, 2'd0, 8'h00, 3'b001, 1'b0, 1'b1, 8'd1, 1'b0}, // R7 unmasked event ignored
        {1'b1, 2'd1, 8'h03, 3'b000, 1'b0, 1'b0, 8'd1, 1'b0}, // R4 enable again: no reload
        {1'b0, 2'd0, 8'h00, 3'b001, 1'b0, 1'b1, 8'd3, 1'b0}, // R7 R8 masked event beats tick
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd2, 1'b0},
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd1, 1'b0},
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 1'b1, 8'd3, 1'b0}, // R8 reload at count 1
        {1'b1, 2'd1, 8'h02, 3'b000, 1'b0, 1'b0, 8'd3, 1'b0}, // disable
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd3, 1'b0}, // R3 tick ignored
        {1'b0, 2'd0, 8'h00, 3'b001, 1'b1, 1'b1, 8'd3, 1'b0}, // R3 reloads ignored
        {1'b1, 2'd0, 8'h01, 3'b000, 1'b0, 1'b0, 8'd3, 1'b0}, // interval 1
        {1'b1, 2'd1, 8'h03, 3'b000, 1'b0, 1'b0, 8'd1, 1'b0}, // R4
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd1, 1'b1}, // R5
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd1, 1'b1}, // R5 fires every tick
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b0, 8'd1, 1'b0}, // R11 no tick, no irq
        {1'b1, 2'd0, 8'h00, 3'b000, 1'b0, 1'b0, 8'd1, 1'b0}, // interval 0
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 1'b0, 8'd0, 1'b0}, // R9 reload loads 0
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd0, 1'b0}, // R9 holds
        {1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 1'b1, 8'd0, 1'b0}  // R9 never fires
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // drive one cycle of inputs, return just after the edge with inputs idle
    task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                        input logic [2:0] e, input logic l, input logic t);
        @(negedge clk);
        we = w; addr = a; wdata = d; evt = e; lrl = l; tick = t;
        @(posedge clk);
        #1;
        we = 1'b0; evt = 3'd0; lrl = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic check_all_zero(input string tag);
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(tag, v, 8'h00);
        end
        check(tag, {7'd0, irq}, 8'h00);
        check(tag, {7'd0, status}, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check_all_zero("R1 reset state");

        for (int i = 0; i < NVEC; i++) begin
            step(TBL[i][24], TBL[i][23:22], TBL[i][21:14], TBL[i][13:11], TBL[i][10], TBL[i][9]);
            check($sformatf("R2-table irq vec %0d", i), {7'd0, irq}, {7'd0, TBL[i][0]});
            rd(2'd3, v);
            check($sformatf("R2-table count vec %0d", i), v, TBL[i][8:1]);
        end

        // R10 sticky status and clear-by-one
        rd(2'd2, v);
        check("R10 status after fires", v, 8'h01);
        step(1'b1, 2'd2, 8'h00, 3'd0, 1'b0, 1'b0);
        check("R10 write 0 keeps status", {7'd0, status}, 8'h01);
        step(1'b1, 2'd2, 8'h01, 3'd0, 1'b0, 1'b0);
        check("R10 write 1 clears status", {7'd0, status}, 8'h00);

        // R10 expiry beats clear in the same cycle
        step(1'b1, 2'd0, 8'h01, 3'd0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 8'h00, 3'd0, 1'b1, 1'b0);
        rd(2'd3, v);
        check("R6 local reload to 1", v, 8'h01);
        step(1'b1, 2'd2, 8'h01, 3'd0, 1'b0, 1'b1);
        check("R10 fire with clear: irq", {7'd0, irq}, 8'h01);
        check("R10 fire with clear: status stays", {7'd0, status}, 8'h01);

        // R7 event 2 admitted by control bit 3, event 1 not admitted
        step(1'b1, 2'd1, 8'h09, 3'd0, 1'b0, 1'b0);
        rd(2'd1, v);
        check("R7 control readback", v, 8'h09);
        step(1'b1, 2'd0, 8'h05, 3'd0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 8'h00, 3'b100, 1'b0, 1'b0);
        rd(2'd3, v);
        check("R7 event 2 reloads", v, 8'h05);
        step(1'b0, 2'd0, 8'h00, 3'b010, 1'b0, 1'b1);
        rd(2'd3, v);
        check("R7 event 1 masked, tick counts", v, 8'h04);

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        check_all_zero("R1 reset mid-run");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule